// File: doc/BRIEF.md
# Saturating Double-Length Accumulator

This block is an accumulator register twice as wide as the data word. Each cycle it takes one of a small set of operations: hold, clear, load, add or subtract. A data word can be placed in the upper half of the register, with zeros below it, or in the lower half. In the lower half it is either zero-extended or sign-extended across the full width. Additions and subtractions work on the full register width in two's complement, so operands of different precision can share one running total.

Two flags come out with the value. The overflow flag records that a signed result left the representable range, and it stays set until a clear. The mid-carry flag shows whether the most recent add or subtract carried out of the lower half into the upper half. This is how a low-half operation reports a carry into the more significant half.

When saturation is enabled, an overflowing result is replaced by the extreme value whose sign matches the true result, much like an analog limiter. With saturation disabled, the wrapped result is kept.

Top module: `satAccumulator`

## Requirements
- R1: After reset the accumulator value, the overflow flag and the mid-carry flag are all zero.
- R2: The operation code is a 3-bit field: 0 hold, 1 clear, 2 load, 3 add, 4 subtract. Codes 5 to 7 act as hold.
- R3: Clear sets the accumulator to zero and clears both flags on the next clock edge.
- R4: Load with highHalf=1 places dataIn in the upper DATA_W bits and zeros in the lower DATA_W bits, whatever signExt is.
- R5: Load with highHalf=0 places dataIn in the lower DATA_W bits. The upper bits are copies of dataIn's top bit when signExt=1 and zeros when signExt=0.
- R6: Add replaces the accumulator with the sum of the accumulator and the aligned operand, modulo 2^(2*DATA_W). A carry out of the top bit is dropped and does not by itself count as overflow.
- R7: Subtract replaces the accumulator with the accumulator minus the aligned operand, modulo 2^(2*DATA_W).
- R8: The overflow flag is set by an add or subtract whose exact signed result lies outside the range of a 2*DATA_W-bit two's complement number. It stays set through hold, load, add and subtract, and only clear or reset lowers it.
- R9: With satEn=1, an overflowing add or subtract leaves the accumulator at the most positive value (0 followed by ones) if the exact result is positive, or at the most negative value (1 followed by zeros) if it is negative. With satEn=0 the wrapped result is kept.
- R10: After each add or subtract, midCarry equals the carry out of the lower DATA_W bits of that operation. For a subtract, this is the carry of the lower half of the accumulator plus the inverted lower half of the operand plus one. Load and clear set midCarry to zero.
- R11: Hold leaves the accumulator value and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | Operation for this cycle |
| dataIn | input | DATA_W | Data word operand |
| highHalf | input | 1 | 1 places the operand in the upper half |
| signExt | input | 1 | Sign-extends a lower-half operand |
| satEn | input | 1 | Enables clamping on overflow |
| accOut | output | 2*DATA_W | Accumulator value |
| ovfFlag | output | 1 | Sticky signed overflow flag |
| midCarry | output | 1 | Carry from lower half into upper half on the last add or subtract |

## Verification
The bench builds the block with DATA_W=4, so the register is 8 bits wide. This puts overflow within one or two operations, and it lets the bench reproduce the classic 4-bit cases exactly. Adding -2 to -2 in the lower half with sign extension gives a carry that is not an overflow. Adding -8 and -4 in the upper half saturates to the most negative value. The narrow width also makes the lower-half carry easy to provoke in both directions, including subtraction with and without borrow.

// File: rtl/satAccPkg.sv
package satAccPkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4
  } accOp_e;

  typedef struct packed {
    logic clr;
    logic load;
    logic arith;
    logic sub;
    logic sat;
  } accStrobe_t;

endpackage

// File: rtl/accControl.sv
module accControl
  import satAccPkg::*;
(
  input  logic [2:0] opCode,
  input  logic       satEn,
  output accStrobe_t strobe
);

  accOp_e opDec;

  always_comb begin
    opDec = accOp_e'(opCode);
    strobe = '0;
    case (opDec)
      OP_CLEAR: strobe.clr = 1'b1;
      OP_LOAD:  strobe.load = 1'b1;
      OP_ADD: begin
        strobe.arith = 1'b1;
        strobe.sat   = satEn;
      end
      OP_SUB: begin
        strobe.arith = 1'b1;
        strobe.sub   = 1'b1;
        strobe.sat   = satEn;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/accAlign.sv
module accAlign #(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic              highHalf,
  input  logic              signExt,
  output logic [ACC_W-1:0]  operand
);

  logic [DATA_W-1:0] fillBits;

  always_comb begin
    fillBits = (signExt && dataIn[DATA_W-1]) ? {DATA_W{1'b1}} : '0;
    if (highHalf) operand = {dataIn, {DATA_W{1'b0}}};
    else          operand = {fillBits, dataIn};
  end

endmodule

// File: rtl/accDatapath.sv
module accDatapath
  import satAccPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W,
  localparam int HALVES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  accStrobe_t       strobe,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] accQ,
  output logic             ovfQ,
  output logic             midCarryQ
);

  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0]  opMux;
  logic [ACC_W-1:0]  rawSum;
  logic [HALVES:0]   chain;
  logic              ovfNow;
  logic [ACC_W-1:0]  nextAcc;

  assign opMux    = strobe.sub ? ~operand : operand;
  assign chain[0] = strobe.sub;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [DATA_W:0] partSum;
    assign partSum = {1'b0, accQ[h*DATA_W +: DATA_W]}
                   + {1'b0, opMux[h*DATA_W +: DATA_W]}
                   + {{DATA_W{1'b0}}, chain[h]};
    assign rawSum[h*DATA_W +: DATA_W] = partSum[DATA_W-1:0];
    assign chain[h+1] = partSum[DATA_W];
  end

  assign ovfNow = (accQ[ACC_W-1] == opMux[ACC_W-1]) &&
                  (rawSum[ACC_W-1] != accQ[ACC_W-1]);

  always_comb begin
    nextAcc = rawSum;
    if (ovfNow && strobe.sat) nextAcc = accQ[ACC_W-1] ? MAX_NEG : MAX_POS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      ovfQ      <= 1'b0;
      midCarryQ <= 1'b0;
    end else if (strobe.clr) begin
      accQ      <= '0;
      ovfQ      <= 1'b0;
      midCarryQ <= 1'b0;
    end else if (strobe.load) begin
      accQ      <= operand;
      midCarryQ <= 1'b0;
    end else if (strobe.arith) begin
      accQ      <= nextAcc;
      ovfQ      <= ovfQ | ovfNow;
      midCarryQ <= chain[1];
    end
  end

endmodule

// File: rtl/satAccumulator.sv
module satAccumulator
  import satAccPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              highHalf,
  input  logic              signExt,
  input  logic              satEn,
  output logic [ACC_W-1:0]  accOut,
  output logic              ovfFlag,
  output logic              midCarry
);

  accStrobe_t       strobe;
  logic [ACC_W-1:0] operand;

  accControl i_ctrl (
    .opCode (opCode),
    .satEn  (satEn),
    .strobe (strobe)
  );

  accAlign #(.DATA_W(DATA_W)) i_align (
    .dataIn   (dataIn),
    .highHalf (highHalf),
    .signExt  (signExt),
    .operand  (operand)
  );

  accDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operand   (operand),
    .accQ      (accOut),
    .ovfQ      (ovfFlag),
    .midCarryQ (midCarry)
  );

endmodule

// File: rtl/satAccChecker.sv
module satAccChecker #(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opCode,
  input logic [DATA_W-1:0] dataIn,
  input logic              highHalf,
  input logic              signExt,
  input logic              satEn,
  input logic [ACC_W-1:0]  accOut,
  input logic              ovfFlag,
  input logic              midCarry
);

  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd1) |=> (accOut == '0 && !ovfFlag && !midCarry)); // R3

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2 && highHalf) |=>
      (accOut == {$past(dataIn), {DATA_W{1'b0}}})); // R4

  AST_LOAD_LOW_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2 && !highHalf && signExt) |=>
      (accOut == {{DATA_W{$past(dataIn[DATA_W-1])}}, $past(dataIn)})); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && opCode != 3'd1) |=> ovfFlag); // R8

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovfFlag) && $past(satEn)) |-> (accOut == MAX_POS || accOut == MAX_NEG)); // R9

  AST_LOAD_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2) |=> !midCarry); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd0 || opCode > 3'd4) |=>
      ($stable(accOut) && $stable(ovfFlag) && $stable(midCarry))); // R11

endmodule

bind satAccumulator satAccChecker #(.DATA_W(DATA_W)) i_satAccChecker (.*);

// File: tb/test_satAccumulator.sv
module test_satAccumulator;

  localparam int DATA_W = 4;
  localparam int ACC_W  = 2 * DATA_W;
  localparam int MAX_V  = (1 << (ACC_W - 1)) - 1;
  localparam int MIN_V  = -(1 << (ACC_W - 1));

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        opCode = 3'd0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              highHalf = 1'b0;
  logic              signExt = 1'b0;
  logic              satEn = 1'b0;
  logic [ACC_W-1:0]  accOut;
  logic              ovfFlag;
  logic              midCarry;

  int numChecks = 0;
  int numFail   = 0;
  bit finished  = 1'b0;

  logic [ACC_W-1:0] mAcc = '0;
  logic             mOvf = 1'b0;
  logic             mCarry = 1'b0;

  always #5 clk = ~clk;

  satAccumulator #(.DATA_W(DATA_W)) i_satAccumulator (.*);

  task automatic chk(input string req, input int act, input int exp);
    numChecks++;
    if (act !== exp) begin
      numFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [DATA_W-1:0] d,
                      input logic hh, input logic se, input logic sat,
                      input string req);
    logic [ACC_W-1:0] opnd;
    int a, o, exact, lo, ol, sumLo;
    if (hh) opnd = {d, {DATA_W{1'b0}}};
    else if (se) opnd = {{DATA_W{d[DATA_W-1]}}, d};
    else opnd = {{DATA_W{1'b0}}, d};
    case (op)
      3'd1: begin mAcc = '0; mOvf = 1'b0; mCarry = 1'b0; end
      3'd2: begin mAcc = opnd; mCarry = 1'b0; end
      3'd3, 3'd4: begin
        a = $signed(mAcc);
        o = $signed(opnd);
        exact = (op == 3'd4) ? a - o : a + o;
        lo = int'(mAcc[DATA_W-1:0]);
        ol = int'(opnd[DATA_W-1:0]);
        sumLo = (op == 3'd4) ? lo + ((~ol) & ((1 << DATA_W) - 1)) + 1 : lo + ol;
        mCarry = ((sumLo >> DATA_W) & 1) != 0;
        if (exact > MAX_V || exact < MIN_V) begin
          mOvf = 1'b1;
          if (sat) exact = (exact > MAX_V) ? MAX_V : MIN_V;
        end
        mAcc = exact[ACC_W-1:0];
      end
      default: ;
    endcase
    @(negedge clk);
    opCode = op; dataIn = d; highHalf = hh; signExt = se; satEn = sat;
    @(negedge clk);
    opCode = 3'd0;
    chk({req, " acc"}, int'(accOut), int'(mAcc));
    chk({req, " ovf"}, int'(ovfFlag), int'(mOvf));
    chk({req, " midCarry"}, int'(midCarry), int'(mCarry));
  endtask

  task automatic testReset();
    chk("R1 acc", int'(accOut), 0);
    chk("R1 ovf", int'(ovfFlag), 0);
    chk("R1 midCarry", int'(midCarry), 0);
  endtask

  task automatic testLoads();
    step(3'd2, 4'hA, 1'b1, 1'b1, 1'b0, "R4 high load");
    chk("R4 literal", int'(accOut), 'hA0);
    step(3'd2, 4'hA, 1'b0, 1'b0, 1'b0, "R5 low zero-ext");
    chk("R5 literal zero", int'(accOut), 'h0A);
    step(3'd2, 4'hA, 1'b0, 1'b1, 1'b0, "R5 low sign-ext");
    chk("R5 literal sign", int'(accOut), 'hFA);
    step(3'd2, 4'h5, 1'b0, 1'b1, 1'b0, "R5 positive sign-ext");
  endtask

  task automatic testCarryNotOverflow();
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd2, 4'hE, 1'b0, 1'b1, 1'b0, "R5 load -2");
    step(3'd3, 4'hE, 1'b0, 1'b1, 1'b0, "R6 -2 plus -2");
    chk("R6 literal", int'(accOut), 'hFC);
    chk("R6 no overflow", int'(ovfFlag), 0);
    chk("R10 low carry", int'(midCarry), 1);
  endtask

  task automatic testSatNegative();
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd2, 4'h8, 1'b1, 1'b0, 1'b1, "R4 load -8 high");
    step(3'd3, 4'hC, 1'b1, 1'b0, 1'b1, "R9 -8 plus -4 saturating");
    chk("R9 literal min", int'(accOut), 'h80);
    chk("R8 literal ovf", int'(ovfFlag), 1);
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear after ovf");
    step(3'd2, 4'h8, 1'b1, 1'b0, 1'b0, "R4 load -8 high");
    step(3'd3, 4'hC, 1'b1, 1'b0, 1'b0, "R9 -8 plus -4 wrapping");
    chk("R9 literal wrap", int'(accOut), 'h40);
  endtask

  task automatic testSatPositive();
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd2, 4'h7, 1'b1, 1'b0, 1'b1, "R4 load 7 high");
    step(3'd3, 4'h7, 1'b1, 1'b0, 1'b1, "R9 positive clamp");
    chk("R9 literal max", int'(accOut), 'h7F);
    step(3'd3, 4'h1, 1'b0, 1'b0, 1'b1, "R9 add at max");
    chk("R9 held at max", int'(accOut), 'h7F);
  endtask

  task automatic testSubtract();
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd2, 4'h3, 1'b0, 1'b0, 1'b0, "R5 load 3");
    step(3'd4, 4'h5, 1'b0, 1'b0, 1'b0, "R7 3 minus 5");
    chk("R7 literal", int'(accOut), 'hFE);
    chk("R10 borrow gives no carry", int'(midCarry), 0);
    step(3'd4, 4'h1, 1'b0, 1'b0, 1'b0, "R7 minus 1");
    chk("R10 no borrow gives carry", int'(midCarry), 1);
    step(3'd2, 4'h8, 1'b1, 1'b0, 1'b1, "R4 load min");
    step(3'd4, 4'h1, 1'b1, 1'b0, 1'b1, "R9 subtract below min");
    chk("R9 literal sub clamp", int'(accOut), 'h80);
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd4, 4'h8, 1'b1, 1'b0, 1'b1, "R9 zero minus min");
    chk("R9 literal neg min", int'(accOut), 'h7F);
  endtask

  task automatic testMidCarry();
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd2, 4'hF, 1'b0, 1'b0, 1'b0, "R5 load 15");
    step(3'd3, 4'h1, 1'b0, 1'b0, 1'b0, "R10 carry into high half");
    chk("R10 literal", int'(accOut), 'h10);
    step(3'd3, 4'h1, 1'b1, 1'b0, 1'b0, "R10 high add no low carry");
    step(3'd2, 4'h1, 1'b0, 1'b0, 1'b0, "R10 load clears carry");
  endtask

  task automatic testStickyAndHold();
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear");
    step(3'd2, 4'h7, 1'b1, 1'b0, 1'b0, "R4 load 7 high");
    step(3'd3, 4'h7, 1'b1, 1'b0, 1'b0, "R8 overflow wrap");
    step(3'd0, 4'h3, 1'b1, 1'b1, 1'b1, "R11 hold");
    step(3'd6, 4'h3, 1'b1, 1'b1, 1'b1, "R2 unused code holds");
    step(3'd2, 4'h1, 1'b0, 1'b0, 1'b0, "R8 load keeps ovf");
    step(3'd3, 4'h1, 1'b0, 1'b0, 1'b0, "R8 add keeps ovf");
    chk("R8 literal sticky", int'(ovfFlag), 1);
    step(3'd1, 4'h0, 1'b0, 1'b0, 1'b0, "R3 clear lowers ovf");
    chk("R3 literal", int'(ovfFlag), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", numChecks, numFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoads();
    testCarryNotOverflow();
    testSatNegative();
    testSatPositive();
    testSubtract();
    testMidCarry();
    testStickyAndHold();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    numChecks++;
    numFail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finish();
  end

endmodule